// File: doc/BRIEF.md
# Interrupt and Event Flag Controller

This block merges three event sources (a watchdog timeout strobe, an alarm match strobe and a supply low-voltage indicator) onto a single interrupt pin. Each source has its own enable bit. An event always records itself in a flags byte, even when its enable is clear. Software reads the flags byte, and that read clears it. At power-up the block also checks the oscillator once and records whether it has failed.

A configuration byte, loaded with a write strobe, holds the enable bits and two output choices. The first choice is the pin style: active-high push-pull, or active-low open-drain. The open-drain style is emulated with a pin value plus a drive-enable. The second choice is the signalling: a held level, or a pulse of fixed width. In level mode the pin stays asserted until software reads the flags. In pulse mode each enabled event gives a pulse of `PULSE_CYC` clock cycles. All pins are plain control and status signals, with no handshake. A strobe is taken in every cycle it is high.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the flags byte is 0x00, the configuration is 0x00 (every enable clear, open-drain, level), and the pin is released: `irq_oe`=0, `irq_pin`=1.
- R2: A `wdt_evt` strobe sets flag bit 0. An `alarm_evt` strobe sets flag bit 1. A rising edge of `pwr_low` sets flag bit 2. Each flag shows on the `flags` output one cycle after its event, whether or not its enable is set.
- R3: In level mode (config bit 4 = 0), a set flag whose enable is set keeps the pin asserted until a flags read. The enables are config bit 0 for the watchdog, bit 1 for the alarm and bit 2 for power-fail.
- R4: An event whose enable is clear sets its flag but never asserts the pin.
- R5: With config bit 3 = 1 the pin is push-pull active-high: `irq_oe` is always 1 and `irq_pin` is 1 when asserted. With bit 3 = 0 the pin is open-drain active-low: when asserted `irq_oe`=1 and `irq_pin`=0, and otherwise `irq_oe`=0 and `irq_pin`=1.
- R6: In push-pull mode `irq_pin` is driven high only while `pwr_low` is 0.
- R7: In pulse mode (config bit 4 = 1), an enabled event asserts the pin for exactly `PULSE_CYC` cycles, starting one cycle after the event. The flags are not changed by this.
- R8: A `flags_rd` strobe clears all four flag bits in the next cycle. An event in the same cycle as the read leaves its own flag set.
- R9: `OSC_WIN` cycles after reset, flag bit 3 is set if `osc_en` is 1 and `osc_running` is 0. Otherwise it stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| wdt_evt | input | 1 | Watchdog timeout strobe |
| alarm_evt | input | 1 | Alarm match strobe |
| pwr_low | input | 1 | Supply below switch threshold (level) |
| osc_en | input | 1 | Oscillator enabled |
| osc_running | input | 1 | Oscillator running status |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte (bits 4..0 used) |
| flags_rd | input | 1 | Flags read strobe (clears on read) |
| irq_pin | output | 1 | Interrupt pin value |
| irq_oe | output | 1 | Interrupt pin drive-enable |
| flags | output | 8 | Flags byte (bits 3..0 used) |

## Verification
The assertions check these on every cycle:
- a power-fail edge always sets its flag;
- a quiet read clears the three event flags;
- an event that coincides with a read survives it;
- the push-pull pin never drives high under low supply and always drives;
- an asserted open-drain level holds until a read or a reconfiguration.

Only the directed scenarios can show the rest:
- the exact pulse width;
- masked events leaving the pin idle;
- the polarity encodings;
- the one-time oscillator check at the end of the power-up window, in both its failed and healthy outcomes.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int FLAG_N   = 4;
  localparam int BYTE_W   = 8;
  localparam int F_WDT    = 0;
  localparam int F_ALM    = 1;
  localparam int F_PF     = 2;
  localparam int F_OSC    = 3;

  typedef struct packed {
    logic pulse_mode;
    logic act_high;
    logic pf_ie;
    logic alm_ie;
    logic wdt_ie;
  } irq_cfg_t;

  localparam int CFG_W = $bits(irq_cfg_t);
endpackage

// File: rtl/irq_evt_flags.sv
module irq_evt_flags
  import irq_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wdt_evt,
  input  logic              alarm_evt,
  input  logic              pwr_low,
  input  logic              osc_fail_set,
  input  logic              clr,
  output logic              pf_evt,
  output logic [FLAG_N-1:0] flag_q
);
  logic              pwr_q;
  logic [FLAG_N-1:0] set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_q <= 1'b0;
    else        pwr_q <= pwr_low;
  end

  assign pf_evt = pwr_low & ~pwr_q;

  always_comb begin
    set_vec        = '0;
    set_vec[F_WDT] = wdt_evt;
    set_vec[F_ALM] = alarm_evt;
    set_vec[F_PF]  = pf_evt;
    set_vec[F_OSC] = osc_fail_set;
  end

  // a set in the same cycle as a clear wins
  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[i] <= 1'b0;
      else if (set_vec[i]) flag_q[i] <= 1'b1;
      else if (clr)        flag_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_osc_watch.sv
module irq_osc_watch #(
  parameter int WIN = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic osc_running,
  output logic fail_set
);
  localparam int CW = $clog2(WIN + 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          at_end;

  assign at_end   = !done_q && (cnt_q == CW'(WIN - 1));
  assign fail_set = at_end && osc_en && !osc_running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      cnt_q  <= cnt_q + 1'b1;
      done_q <= at_end;
    end
  end
endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic active
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (trig)        cnt_q <= CW'(WIDTH);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int PULSE_CYC = 8,
  parameter int OSC_WIN   = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wdt_evt,
  input  logic              alarm_evt,
  input  logic              pwr_low,
  input  logic              osc_en,
  input  logic              osc_running,
  input  logic              cfg_wr,
  input  logic [BYTE_W-1:0] cfg_wdata,
  input  logic              flags_rd,
  output logic              irq_pin,
  output logic              irq_oe,
  output logic [BYTE_W-1:0] flags
);
  irq_cfg_t          cfg_q;
  logic [FLAG_N-1:0] flag_q;
  logic              pf_evt;
  logic              osc_fail_set;
  logic              pend_lvl;
  logic              trig;
  logic              pulse_act;
  logic              asserted;
  logic              cfg_act_high;
  logic              cfg_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_wr) cfg_q <= irq_cfg_t'(cfg_wdata[CFG_W-1:0]);
  end

  assign cfg_act_high = cfg_q.act_high;
  assign cfg_pulse    = cfg_q.pulse_mode;

  irq_osc_watch #(.WIN(OSC_WIN)) u_osc (
    .clk         (clk),
    .rst_n       (rst_n),
    .osc_en      (osc_en),
    .osc_running (osc_running),
    .fail_set    (osc_fail_set)
  );

  irq_evt_flags u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .wdt_evt      (wdt_evt),
    .alarm_evt    (alarm_evt),
    .pwr_low      (pwr_low),
    .osc_fail_set (osc_fail_set),
    .clr          (flags_rd),
    .pf_evt       (pf_evt),
    .flag_q       (flag_q)
  );

  assign pend_lvl = (flag_q[F_WDT] & cfg_q.wdt_ie) |
                    (flag_q[F_ALM] & cfg_q.alm_ie) |
                    (flag_q[F_PF]  & cfg_q.pf_ie);

  assign trig = cfg_q.pulse_mode &
                ((wdt_evt & cfg_q.wdt_ie) |
                 (alarm_evt & cfg_q.alm_ie) |
                 (pf_evt & cfg_q.pf_ie));

  irq_pulse_gen #(.WIDTH(PULSE_CYC)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig   (trig),
    .active (pulse_act)
  );

  assign asserted = cfg_q.pulse_mode ? pulse_act : pend_lvl;

  always_comb begin
    if (cfg_q.act_high) begin
      irq_oe  = 1'b1;
      irq_pin = asserted & ~pwr_low;
    end else begin
      irq_oe  = asserted;
      irq_pin = ~asserted;
    end
  end

  assign flags = BYTE_W'(flag_q);
endmodule

// File: rtl/irq_flag_chk.sv
module irq_flag_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wdt_evt,
  input logic       alarm_evt,
  input logic       pwr_low,
  input logic       flags_rd,
  input logic       cfg_wr,
  input logic       irq_pin,
  input logic       irq_oe,
  input logic [7:0] flags,
  input logic       act_high,
  input logic       pulse_mode
);
  AST_PF_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_low) |=> flags[2]); // R2

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_rd && !wdt_evt && !alarm_evt && !pwr_low) |=> (flags[2:0] == 3'b000)); // R8

  AST_READ_KEEPS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_rd && wdt_evt) |=> flags[0]); // R8

  AST_PP_LOW_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (act_high && irq_pin) |-> !pwr_low); // R6

  AST_PP_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    act_high |-> irq_oe); // R5

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_high && !pulse_mode && irq_oe && !flags_rd && !cfg_wr) |=> irq_oe); // R3
endmodule

bind irq_flag_ctrl irq_flag_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wdt_evt    (wdt_evt),
  .alarm_evt  (alarm_evt),
  .pwr_low    (pwr_low),
  .flags_rd   (flags_rd),
  .cfg_wr     (cfg_wr),
  .irq_pin    (irq_pin),
  .irq_oe     (irq_oe),
  .flags      (flags),
  .act_high   (cfg_act_high),
  .pulse_mode (cfg_pulse)
);

// File: tb/sim_irq_flag_ctrl.sv
module sim_irq_flag_ctrl;
  localparam int PULSE_CYC = 8;
  localparam int OSC_WIN   = 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wdt_evt = 1'b0, alarm_evt = 1'b0, pwr_low = 1'b0;
  logic       osc_en = 1'b1, osc_running = 1'b0;
  logic       cfg_wr = 1'b0, flags_rd = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       irq_pin, irq_oe;
  logic [7:0] flags;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  irq_flag_ctrl #(.PULSE_CYC(PULSE_CYC), .OSC_WIN(OSC_WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .wdt_evt(wdt_evt), .alarm_evt(alarm_evt),
    .pwr_low(pwr_low), .osc_en(osc_en), .osc_running(osc_running),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .flags_rd(flags_rd),
    .irq_pin(irq_pin), .irq_oe(irq_oe), .flags(flags)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    cfg_wdata = v; cfg_wr = 1'b1; step(1); cfg_wr = 1'b0;
  endtask

  task automatic rd_flags();
    flags_rd = 1'b1; step(1); flags_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk(flags == 8'h00, "R1 flags", flags, 0);
    chk(irq_oe == 1'b0 && irq_pin == 1'b1, "R1 pin released", {irq_oe, irq_pin}, 2'b01);
  endtask

  task automatic t_osc_fail();
    step(10);
    chk(flags[3] == 1'b0, "R9 before window", flags, 0);
    step(OSC_WIN);
    chk(flags == 8'h08, "R9 osc fail set", flags, 8'h08);
    rd_flags();
    chk(flags == 8'h00, "R8 read clears osc flag", flags, 0);
  endtask

  task automatic t_masked();
    wr_cfg(8'h00);
    alarm_evt = 1'b1; step(1); alarm_evt = 1'b0;
    chk(flags == 8'h02, "R2 alarm flag masked", flags, 8'h02);
    for (int i = 0; i < 4; i++) begin
      chk(irq_oe == 1'b0, "R4 masked pin idle", irq_oe, 0);
      step(1);
    end
    wdt_evt = 1'b1; step(1); wdt_evt = 1'b0;
    chk(flags == 8'h03 && irq_oe == 1'b0, "R4 masked watchdog", flags, 8'h03);
    rd_flags();
    chk(flags == 8'h00, "R8 clear", flags, 0);
  endtask

  task automatic t_level();
    wr_cfg(8'h01);
    chk(irq_oe == 1'b0, "R3 idle before event", irq_oe, 0);
    wdt_evt = 1'b1; step(1); wdt_evt = 1'b0;
    chk(flags == 8'h01, "R2 watchdog flag", flags, 8'h01);
    chk(irq_oe == 1'b1 && irq_pin == 1'b0, "R5 open-drain asserted", {irq_oe, irq_pin}, 2'b10);
    step(5);
    chk(irq_oe == 1'b1, "R3 level held", irq_oe, 1);
    rd_flags();
    chk(irq_oe == 1'b0 && irq_pin == 1'b1, "R3 released by read", {irq_oe, irq_pin}, 2'b01);
  endtask

  task automatic t_push_pull();
    wr_cfg(8'h0A);
    chk(irq_oe == 1'b1 && irq_pin == 1'b0, "R5 push-pull idle", {irq_oe, irq_pin}, 2'b10);
    alarm_evt = 1'b1; step(1); alarm_evt = 1'b0;
    chk(irq_oe == 1'b1 && irq_pin == 1'b1, "R5 push-pull asserted", {irq_oe, irq_pin}, 2'b11);
    rd_flags();
    chk(irq_pin == 1'b0, "R5 push-pull released", irq_pin, 0);
  endtask

  task automatic t_supply();
    wr_cfg(8'h0C);
    pwr_low = 1'b1; step(1);
    chk(flags == 8'h04, "R2 power-fail flag", flags, 8'h04);
    chk(irq_pin == 1'b0, "R6 no high under low supply", irq_pin, 0);
    step(2);
    chk(irq_pin == 1'b0, "R6 still low", irq_pin, 0);
    pwr_low = 1'b0; step(1);
    chk(irq_pin == 1'b1, "R6 high once supply back", irq_pin, 1);
    rd_flags();
    chk(irq_pin == 1'b0 && flags == 8'h00, "R8 clear after power-fail", flags, 0);
  endtask

  task automatic t_pulse();
    int n;
    wr_cfg(8'h11);
    wdt_evt = 1'b1; step(1); wdt_evt = 1'b0;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      if (irq_oe) n++;
      step(1);
    end
    chk(n == PULSE_CYC, "R7 pulse width", n, PULSE_CYC);
    chk(flags == 8'h01, "R7 flag kept in pulse mode", flags, 8'h01);
    rd_flags();
    alarm_evt = 1'b1; step(1); alarm_evt = 1'b0;
    chk(irq_oe == 1'b0, "R7 masked alarm no pulse", irq_oe, 0);
    rd_flags();
  endtask

  task automatic t_collide();
    wr_cfg(8'h00);
    alarm_evt = 1'b1; step(1); alarm_evt = 1'b0;
    flags_rd = 1'b1; wdt_evt = 1'b1; step(1);
    flags_rd = 1'b0; wdt_evt = 1'b0;
    chk(flags == 8'h01, "R8 event survives read", flags, 8'h01);
    rd_flags();
    chk(flags == 8'h00, "R8 plain read clears", flags, 0);
  endtask

  task automatic t_osc_ok();
    osc_running = 1'b1;
    do_reset();
    step(OSC_WIN + 5);
    chk(flags == 8'h00, "R9 running osc no flag", flags, 0);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_osc_fail();
    t_masked();
    t_level();
    t_push_pull();
    t_supply();
    t_pulse();
    t_collide();
    t_osc_ok();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule